// File: doc/BRIEF.md
# Ripple-Carry Arithmetic/Logic Unit with Signed Compare

This block is a purely combinational arithmetic and logic unit for a datapath. It takes two operands and a 4-bit operation code and returns a result word, a flag that is set when the result is all zeros, and a flag for signed overflow. The default width is 32 bits. Six operations are decoded. Bitwise AND, OR and NOR cover the logic cases. Add and subtract cover arithmetic. A signed less-than compare returns 1 or 0 in the least significant bit.

Internally the operands pass through one identical bit cell per position. Each cell can invert its A bit and its B bit, forms the AND, OR and full-adder sum, and passes its carry to the cell above. Subtract is built from the same chain: it inverts B and forces a carry of one into bit 0. NOR inverts both operands and takes the AND output. The signed compare runs a subtraction. The top cell turns the sign of that subtraction into a less-than bit, corrected for overflow, and feeds it back into bit 0. Every other result bit is held at zero. A typical user is the execute stage of a simple processor. It tests two registers for equality by subtracting them and reading the zero flag.

Top module: `alu_ripple`

## Requirements
- R1: Operation code 4'b0000 returns the bitwise AND of A and B.
- R2: Operation code 4'b0001 returns the bitwise OR of A and B.
- R3: Operation code 4'b0010 returns A plus B modulo 2^WIDTH.
- R4: Operation code 4'b0110 returns A minus B modulo 2^WIDTH, formed by inverting B and carrying one into bit 0.
- R5: Operation code 4'b0111 returns 1 in bit 0 when A is less than B as two's-complement numbers, and 0 otherwise. All upper bits are 0. The result is correct even when the internal subtraction overflows.
- R6: Operation code 4'b1100 returns the bitwise NOR of A and B.
- R7: For a listed operation code, the zero flag is 1 exactly when every result bit is 0.
- R8: The overflow flag is raised only for add and subtract, when the signed result does not fit in WIDTH bits. It is 0 for all other codes.
- R9: Any code other than the six listed gives a result of zero, with both flags at 0.
- R10: Subtracting two equal operands sets the zero flag. Subtracting two unequal operands clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation code |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| res_o | output | WIDTH | Result word |
| zero_o | output | 1 | Result is all zeros (listed codes only) |
| ovf_o | output | 1 | Signed overflow on add or subtract |

## Verification
The block holds no state, so a fault in the carry chain, an inversion control or the feedback of the compare bit shows up at the ports in the same evaluation as the stimulus. A wrong carry shows as a wrong sum or a flipped overflow bit. A misrouted compare bit shows as a nonzero upper result or a wrong verdict. The riskiest operand pairs are those whose difference overflows, such as the most negative value against positive values. These give a wrong compare answer if the sign is used without the overflow correction. The bench applies one vector per clock and compares all three outputs against an arithmetic reference half a cycle later.

// File: rtl/alu_ripple.sv
module alu_ripple #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] res_o,
  output logic             zero_o,
  output logic             ovf_o
);
  localparam int MSB = WIDTH - 1;

  logic       inv_a, inv_b, known, arith;
  logic [1:0] pick;
  logic [WIDTH-1:0] raw;
  logic       ovf_raw;

  assign inv_a = op_i[3];
  assign inv_b = op_i[2];
  assign pick  = op_i[1:0];
  assign known = (op_i == 4'b0000) || (op_i == 4'b0001) || (op_i == 4'b0010) ||
                 (op_i == 4'b0110) || (op_i == 4'b0111) || (op_i == 4'b1100);
  assign arith = (op_i == 4'b0010) || (op_i == 4'b0110);

  always_comb begin
    logic [WIDTH:0]   cy;
    logic [WIDTH-1:0] ax, bx, sum;
    logic             lt;
    cy    = '0;
    cy[0] = inv_b;
    ax    = '0;
    bx    = '0;
    sum   = '0;
    for (int i = 0; i < WIDTH; i++) begin
      ax[i]   = a_i[i] ^ inv_a;
      bx[i]   = b_i[i] ^ inv_b;
      sum[i]  = ax[i] ^ bx[i] ^ cy[i];
      cy[i+1] = (ax[i] & bx[i]) | (cy[i] & (ax[i] ^ bx[i]));
    end
    ovf_raw = cy[MSB] ^ cy[WIDTH];
    lt      = sum[MSB] ^ ovf_raw;
    raw     = '0;
    for (int i = 0; i < WIDTH; i++) begin
      case (pick)
        2'b00:   raw[i] = ax[i] & bx[i];
        2'b01:   raw[i] = ax[i] | bx[i];
        2'b10:   raw[i] = sum[i];
        default: raw[i] = (i == 0) ? lt : 1'b0;
      endcase
    end
  end

  assign res_o  = known ? raw : '0;
  assign zero_o = known && (res_o == '0);
  assign ovf_o  = arith && ovf_raw;
endmodule

// File: rtl/alu_ripple_chk.sv
module alu_ripple_chk #(
  parameter int WIDTH = 32
) (
  input logic [3:0]       op_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic [WIDTH-1:0] res_o,
  input logic             zero_o,
  input logic             ovf_o
);
  always_comb begin
    if (op_i == 4'b0010) AST_ADD_SUM: assert (res_o == a_i + b_i); // R3
    if (op_i == 4'b0110) AST_SUB_DIFF: assert (res_o == a_i - b_i); // R4
    if (op_i == 4'b0111) AST_SLT_UPPER_CLEAR: assert (res_o[WIDTH-1:1] == '0); // R5
    if (op_i == 4'b0111) AST_SLT_VERDICT: assert (res_o[0] == ($signed(a_i) < $signed(b_i))); // R5
    if (zero_o) AST_ZERO_MEANS_CLEAR: assert (res_o == '0); // R7
    if (op_i != 4'b0010 && op_i != 4'b0110) AST_NO_OVERFLOW: assert (!ovf_o); // R8
    if (!(op_i inside {4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100}))
      AST_UNLISTED_QUIET: assert (res_o == '0 && !zero_o && !ovf_o); // R9
  end
endmodule

bind alu_ripple alu_ripple_chk #(.WIDTH(WIDTH)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .res_o(res_o), .zero_o(zero_o), .ovf_o(ovf_o)
);

// File: tb/alu_ripple_tb_top.sv
module alu_ripple_tb_top;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op;
  logic [W-1:0] a, b, res;
  logic         zero, ovf;
  int           checks = 0;
  int           errors = 0;
  int           ticks = 0;
  bit           done = 0;

  always #4 clk = ~clk;

  alu_ripple #(.WIDTH(W)) dut_i (
    .op_i(op), .a_i(a), .b_i(b), .res_o(res), .zero_o(zero), .ovf_o(ovf)
  );

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'b0000: return "R1";
      4'b0001: return "R2";
      4'b0010: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      4'b1100: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic check_now();
    longint sa, sb, full;
    logic [W-1:0] er;
    logic ez, eo, listed;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    listed = 1'b1;
    eo = 1'b0;
    case (op)
      4'b0000: er = a & b;
      4'b0001: er = a | b;
      4'b0010: begin full = sa + sb; er = W'(full);
                     eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
      4'b0110: begin full = sa - sb; er = W'(full);
                     eo = (full > 64'sd2147483647) || (full < -64'sd2147483648); end
      4'b0111: er = (sa < sb) ? W'(1) : W'(0);
      4'b1100: er = ~(a | b);
      default: begin er = '0; listed = 1'b0; end
    endcase
    ez = listed && (er == '0);
    checks++;
    if (res !== er) begin
      errors++;
      $display("FAIL %s result op=%b a=%h b=%h actual=%h expected=%h", tag_of(op), op, a, b, res, er);
    end
    checks++;
    if (zero !== ez) begin
      errors++;
      $display("FAIL %s zero flag op=%b a=%h b=%h actual=%b expected=%b",
               (op == 4'b0110) ? "R10" : (listed ? "R7" : "R9"), op, a, b, zero, ez);
    end
    checks++;
    if (ovf !== eo) begin
      errors++;
      $display("FAIL R8 overflow op=%b a=%h b=%h actual=%b expected=%b", op, a, b, ovf, eo);
    end
  endtask

  task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    @(negedge clk);
    check_now();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    ticks++;
    if (ticks > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [3:0] codes [6];
    codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100};
    op = 4'b0000; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-time state: AND of zeros gives zero result and zero flag set (R1, R7)
    @(negedge clk);
    check_now();
    // R1 R2 R6 logic patterns
    apply(4'b0000, 32'hF0F0_1234, 32'hFF00_00FF);
    apply(4'b0001, 32'hF0F0_1234, 32'h0F00_0001);
    apply(4'b1100, 32'hF0F0_1234, 32'h0F00_0001);
    apply(4'b1100, 32'hFFFF_FFFF, 32'h0);
    // R3 add with carry out and signed overflow (R8)
    apply(4'b0010, 32'hFFFF_FFFF, 32'h1);
    apply(4'b0010, 32'h7FFF_FFFF, 32'h1);
    apply(4'b0010, 32'h8000_0000, 32'h8000_0000);
    // R4 subtract, R10 equality via zero flag
    apply(4'b0110, 32'h1234_5678, 32'h1234_5678);
    apply(4'b0110, 32'h1234_5678, 32'h1234_5679);
    apply(4'b0110, 32'h8000_0000, 32'h1);
    apply(4'b0110, 32'h7FFF_FFFF, 32'hFFFF_FFFF);
    // R5 signed compare including overflowing differences
    apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
    apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
    apply(4'b0111, 32'hFFFF_FFFF, 32'h0);
    apply(4'b0111, 32'h5, 32'h5);
    apply(4'b0111, 32'h3, 32'h9);
    // R9 unlisted codes stay silent
    for (int k = 0; k < 16; k++)
      if (tag_of(4'(k)) == "R9") apply(4'(k), 32'hDEAD_BEEF, 32'h0123_4567);
    // random sweep across all codes (R1-related coverage through tag_of)
    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      logic [W-1:0] x, y;
      int pick;
      pick = $urandom_range(0, 7);
      o = (pick < 6) ? codes[pick] : 4'($urandom_range(0, 15));
      x = $urandom();
      y = (n % 5 == 0) ? x : $urandom();
      if (n % 7 == 0) x = {1'b1, 31'($urandom_range(0, 3))};
      apply(o, x, y);
    end
    finish_run();
  end
endmodule